// File: doc/BRIEF.md
# I2C Clock-Stretch Timeout Watchdog

This block sits beside an I2C master and watches the SCL line for a remote slave that holds the clock low for too long. Software programs an 8-bit limit. The block turns that limit into a 12-bit down-counter value by placing the limit in the upper eight bits and zeros in the low nibble. The counter runs down on each qualified tick while the synchronized SCL stays low. Any high level on SCL, however short, reloads the counter, so only a single unbroken low period is ever measured.

When the counter runs out, a sticky timeout flag is set. The counter then parks until SCL is released. The flag drives an interrupt request when the interrupt enable bit is set. Software clears the flag by writing 1 to it. A limit of 0 or 1 disables the watchdog.

All pins are plain control and status signals. The register port is a single-cycle write strobe with a combinational read mux. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `scl_stretch_watchdog`

## Requirements
- R1: After reset, the limit register (address 0) reads 0, the control register (address 1) reads 0, and `irq_o` is 0.
- R2: While synchronized SCL is low, the counter decrements once per clock in which `tick_i` is 1. Clocks with `tick_i` at 0 do not count.
- R3: SCL passes through a two-flop synchronizer. With `tick_i` held at 1 and a limit L of 2 or more, the flag first reads 1 exactly L*16+2 clock edges after SCL is sampled low, and it reads 0 one edge earlier.
- R4: Any high level on SCL, even for a single clock, reloads the counter from the limit. The next low period then takes the full L*16 ticks to time out.
- R5: A limit of 0 or 1 never produces a timeout, however long SCL stays low.
- R6: Address 0 holds the limit in bits 7:0, read/write. Address 1 holds the timeout flag in bit 0 and the interrupt enable in bit 1, which is read/write. All other bits, and all other addresses, read as 0 and ignore writes.
- R7: Writing 1 to address 1 bit 0 clears the flag. Writing 0 to that bit leaves the flag unchanged.
- R8: If a timeout and a flag clear occur on the same clock edge, the flag ends up set.
- R9: After a timeout, the counter stops until SCL goes high. A flag cleared while SCL is still low stays clear for the rest of that low period.
- R10: `irq_o` is 1 exactly when both the flag and the interrupt enable bit are 1.
- R11: A limit written while SCL is high takes effect for the next low period. A limit written during a low period does not change that period; it is used from the next reload onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| tick_i | input | 1 | Count qualifier, one decrement per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Timeout interrupt request |

## Verification
The bench sweeps limits 2 to 40, plus 128 and 255, and checks the flag on the edge before and on the edge of the expected timeout. An off-by-one in the load value, the nibble placement or the synchronizer depth would move that edge and fail the check. Separate tests cover:
- a one-clock SCL glitch, which a design without reload would answer with an early timeout;
- a clear on the same edge as a timeout, where a design that gives the clear priority would lose the event;
- a clear during a long low period, where a counter that does not park would fire again;
- limits of 0 and 1, where a design without the disable rule would fire after 0 or 16 ticks;
- a mid-period limit write, where a design that applies the write at once would fire at the wrong count;
- withheld ticks, which must push the timeout later by the same number of clocks.

// File: rtl/scl_to_pkg.sv
package scl_to_pkg;
  // register addresses
  localparam int ADDR_LIMIT = 0;
  localparam int ADDR_CTRL  = 1;
  // control register bit positions
  localparam int BIT_FLAG   = 0;
  localparam int BIT_IE     = 1;
  // smallest limit that arms the watchdog
  localparam int MIN_LIMIT  = 2;
endpackage

// File: rtl/scl_to_sync.sv
module scl_to_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_to_counter.sv
module scl_to_counter
  import scl_to_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o
);
  localparam int LOW_W = CNT_W - LIM_W;

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             done_q;
  logic             step;

  assign step  = !scl_s_i && tick_i && armed_q && !done_q;
  assign hit_o = step && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (scl_s_i) begin
      cnt_q   <= {limit_i, {LOW_W{1'b0}}};
      armed_q <= (limit_i >= LIM_W'(MIN_LIMIT));
      done_q  <= 1'b0;
    end else if (hit_o) begin
      cnt_q   <= '0;
      done_q  <= 1'b1;
    end else if (step && (cnt_q != '0)) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  AST_RELOAD_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s_i |=> cnt_q == {$past(limit_i), {LOW_W{1'b0}}}); // R4
  AST_ONE_PER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_s_i && !tick_i) |=> $stable(cnt_q)); // R2
  AST_PARKED_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !scl_s_i) |=> ($stable(cnt_q) && !hit_o)); // R9
  AST_HIT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> !scl_s_i); // R3
endmodule

// File: rtl/scl_to_regs.sv
module scl_to_regs
  import scl_to_pkg::*;
#(
  parameter int LIM_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              hit_i,
  output logic [LIM_W-1:0]  limit_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [LIM_W-1:0] limit_q;
  logic             flag_q;
  logic             ie_q;
  logic             wr_limit;
  logic             wr_ctrl;
  logic             clr;
  logic             unused_wr;

  assign wr_limit  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_LIMIT));
  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign clr       = wr_ctrl && wr_data_i[BIT_FLAG];
  assign unused_wr = ^wr_data_i[DATA_W-1:LIM_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      ie_q    <= 1'b0;
    end else begin
      if (wr_limit) limit_q <= wr_data_i[LIM_W-1:0];
      if (wr_ctrl)  ie_q    <= wr_data_i[BIT_IE];
    end
  end

  // the set has priority over a same-edge clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (hit_i) flag_q <= 1'b1;
    else if (clr)   flag_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_LIMIT)) begin
      rd_data_o[LIM_W-1:0] = limit_q;
    end else if (rd_addr_i == ADDR_W'(ADDR_CTRL)) begin
      rd_data_o[BIT_FLAG] = flag_q;
      rd_data_o[BIT_IE]   = ie_q;
    end
  end

  assign limit_o = limit_q;
  assign flag_o  = flag_q;
  assign ie_o    = ie_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_q); // R8
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit_i) |=> !flag_q); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R7
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_limit |=> $stable(limit_q)); // R6
endmodule

// File: rtl/scl_stretch_watchdog.sv
module scl_stretch_watchdog #(
  parameter int CNT_W       = 12,
  parameter int LIM_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic             scl_s;
  logic             hit;
  logic [LIM_W-1:0] limit;
  logic             flag;
  logic             ie;

  scl_to_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  scl_to_counter #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s_i (scl_s),
    .tick_i  (tick_i),
    .limit_i (limit),
    .hit_o   (hit)
  );

  scl_to_regs #(.LIM_W(LIM_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .hit_i     (hit),
    .limit_o   (limit),
    .flag_o    (flag),
    .ie_o      (ie),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = flag && ie;

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ie) |=> irq_o); // R10
endmodule

// File: tb/scl_stretch_watchdog_tb.sv
`timescale 1ns/1ps
module scl_stretch_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_i = 1'b1;
  logic        tick_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic ie = 1'b1;

  always #10 clk = ~clk; // 50 MHz

  scl_stretch_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic flag_is(input string req, input logic exp);
    logic [31:0] v;
    rd(2'd1, v);
    check(req, {31'b0, v[0]}, {31'b0, exp});
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic clear_flag();
    wr(2'd1, {30'b0, ie, 1'b1});
  endtask

  task automatic release_scl();
    scl_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // scl is high and flag clear on entry; limit already programmed
  task automatic measure(input string req, input int lim);
    int n = lim * 16;
    scl_i = 1'b0;
    repeat (n + 1) @(negedge clk);
    flag_is(req, 1'b0);
    @(negedge clk);
    flag_is(req, 1'b1);
    check({req, " irq"}, {31'b0, irq_o}, {31'b0, ie});
    release_scl();
    flag_is({req, " sticky"}, 1'b1);
    clear_flag();
    flag_is({req, " cleared"}, 1'b0);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); check("R1 limit", v, 32'h0);
    rd(2'd1, v); check("R1 ctrl", v, 32'h0);
    check("R1 irq", {31'b0, irq_o}, 32'h0);

    // R6 field masking and unused address
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R6 limit mask", v, 32'hFF);
    wr(2'd0, 32'h0000_0A00); rd(2'd0, v); check("R6 upper ignored", v, 32'h0);
    wr(2'd1, 32'hFFFF_FFFE); rd(2'd1, v); check("R6 ctrl mask", v, 32'h2);
    rd(2'd2, v); check("R6 addr2", v, 32'h0);

    // R5 disabled settings
    for (int lim = 0; lim < 2; lim++) begin
      wr(2'd0, lim);
      scl_i = 1'b0;
      repeat (600) @(negedge clk);
      flag_is("R5 disabled", 1'b0);
      release_scl();
    end

    // R3 sweep
    for (int lim = 2; lim <= 40; lim++) begin
      wr(2'd0, lim);
      measure("R3 sweep", lim);
    end
    wr(2'd0, 128); measure("R3 lim128", 128);
    wr(2'd0, 255); measure("R3 lim255", 255);

    // R4 one-cycle glitch restarts count
    wr(2'd0, 3);
    scl_i = 1'b0;
    repeat (44) @(negedge clk);
    scl_i = 1'b1;
    @(negedge clk);
    measure("R4 glitch reload", 3);

    // R8 clear on the same edge as the timeout, then R9 parking
    wr(2'd0, 2);
    scl_i = 1'b0;
    repeat (33) @(negedge clk);
    flag_is("R8 pre", 1'b0);
    clear_flag();
    flag_is("R8 set wins", 1'b1);
    clear_flag();
    flag_is("R9 cleared", 1'b0);
    repeat (200) @(negedge clk);
    flag_is("R9 no refire while low", 1'b0);
    check("R9 irq", {31'b0, irq_o}, 32'h0);
    release_scl();
    measure("R9 fires after release", 2);

    // R7 writing zero to the flag bit
    scl_i = 1'b0;
    repeat (34) @(negedge clk);
    wr(2'd1, {30'b0, ie, 1'b0});
    flag_is("R7 write0 keeps", 1'b1);
    clear_flag();
    flag_is("R7 write1 clears", 1'b0);
    release_scl();

    // R10 interrupt masking
    ie = 1'b0;
    wr(2'd1, 32'h0);
    scl_i = 1'b0;
    repeat (34) @(negedge clk);
    flag_is("R10 flag", 1'b1);
    check("R10 masked", {31'b0, irq_o}, 32'h0);
    ie = 1'b1;
    wr(2'd1, 32'h2);
    check("R10 enabled", {31'b0, irq_o}, 32'h1);
    clear_flag();
    check("R10 cleared", {31'b0, irq_o}, 32'h0);
    release_scl();

    // R11 limit write during low period
    wr(2'd0, 2);
    scl_i = 1'b0;
    repeat (10) @(negedge clk);
    wr(2'd0, 5);
    repeat (32 + 1 - 11) @(negedge clk);
    flag_is("R11 old limit pre", 1'b0);
    @(negedge clk);
    flag_is("R11 old limit used", 1'b1);
    rd(2'd0, v); check("R11 readback", v, 32'd5);
    release_scl();
    clear_flag();
    measure("R11 new limit", 5);

    // R2 withheld ticks delay the timeout
    wr(2'd0, 2);
    scl_i = 1'b0;
    repeat (5) @(negedge clk);
    tick_i = 1'b0;
    repeat (10) @(negedge clk);
    tick_i = 1'b1;
    repeat (32 + 2 + 10 - 15 - 1) @(negedge clk);
    flag_is("R2 gated pre", 1'b0);
    @(negedge clk);
    flag_is("R2 gated fire", 1'b1);
    release_scl();
    clear_flag();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule